// File: doc/BRIEF.md
# Filtered External Clock Edge Conditioner

This block turns an asynchronous external clock pin into single-cycle count-enable pulses for a low-power timer counter. Everything runs on an internal sampling clock. The pin first goes through a synchroniser. It then goes through a stability filter that changes its output level only after the new level has held for a selected number of sampling cycles. An edge detector then produces one pulse for each accepted rising edge, falling edge, or either edge, as the polarity setting selects.

Both configuration fields may change while the block runs. When either field changes, the filter's run count restarts and the filtered level stays as it is. The reserved polarity code blocks all pulses and raises an error flag. Both-edge counting needs the sampling clock to run at least four times faster than the external clock.

Top module: `extclk_edge_cond`

## Requirements
- R1: With `flt_sel_i` = 0, the filtered level follows every change of the synchronised pin after one sample.
- R2: With `flt_sel_i` = 1, 2 or 3, the filtered level takes a new pin level only after that level has held for 2, 4 or 8 consecutive samples.
- R3: A pin level that holds for fewer samples than the selected count produces no count pulse.
- R4: With `pol_sel_i` = 0, each accepted rising edge of the filtered level produces a pulse.
- R5: With `pol_sel_i` = 1, each accepted falling edge produces a pulse.
- R6: With `pol_sel_i` = 2, every accepted edge, rising or falling, produces a pulse.
- R7: With `pol_sel_i` = 3, `cfg_err_o` is 1 and no pulse is produced. With any other code, `cfg_err_o` is 0.
- R8: Each accepted edge gives exactly one pulse, one sampling cycle wide.
- R9: After reset, the filtered level is 0 and `cnt_pulse_o` is 0. A pin that is low from reset onward never produces a pulse.
- R10: A change of either field clears the filter run count and leaves the filtered level unchanged.
- R11: The pulse appears N+3 sampling cycles after the pin changes, where N is the selected stability count (1, 2, 4 or 8). Two of these cycles are synchroniser stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Raw asynchronous external clock pin |
| flt_sel_i | input | 2 | Stability count select: 0→1, 1→2, 2→4, 3→8 samples |
| pol_sel_i | input | 2 | Active edge: 0 rising, 1 falling, 2 both, 3 reserved |
| cnt_pulse_o | output | 1 | One-cycle count-enable pulse |
| cfg_err_o | output | 1 | Reserved polarity code selected |

## Verification
The block is driven with random pin levels held for random run lengths, both shorter and longer than the selected stability count. This tells correct glitch rejection apart from off-by-one threshold errors. Random field changes in the middle of a run show whether the run count is cleared and whether the level is kept. Directed cases cover three things: the exact pulse latency at count 4, an 8-count filter fed a 7-cycle pulse, and the reserved polarity code. Each cycle the pulse is compared against an independent cycle model, which separates the rising, falling and both-edge selections.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    typedef enum logic [1:0] {
        POL_RISE = 2'd0,
        POL_FALL = 2'd1,
        POL_BOTH = 2'd2,
        POL_RSVD = 2'd3
    } pol_e;

    localparam int unsigned SEL_W = 2;

endpackage

// File: rtl/ecc_sync.sv
module ecc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (STAGES > 1) begin
            st_d.chain = {st_q.chain[STAGES-2:0], async_i};
        end else begin
            st_d.chain[0] = async_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.chain[STAGES-1];
endmodule

// File: rtl/ecc_stab_filter.sv
module ecc_stab_filter #(
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             smp_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             clr_i,
    output logic             lvl_o
);
    localparam int unsigned MAX_RUN = 1 << ((1 << SEL_W) - 1);
    localparam int unsigned RUN_W   = (MAX_RUN > 1) ? $clog2(MAX_RUN) : 1;

    typedef struct packed {
        logic             lvl;
        logic [RUN_W-1:0] run;
    } flt_st_t;

    flt_st_t        st_d, st_q;
    logic [RUN_W:0] need;
    logic [RUN_W:0] seen;

    always_comb begin
        st_d = st_q;
        need = {{RUN_W{1'b0}}, 1'b1} << sel_i;
        seen = {1'b0, st_q.run} + {{RUN_W{1'b0}}, 1'b1};
        if (clr_i) begin
            st_d.run = '0;
        end else if (smp_i == st_q.lvl) begin
            st_d.run = '0;
        end else if (seen >= need) begin
            st_d.lvl = smp_i;
            st_d.run = '0;
        end else begin
            st_d.run = seen[RUN_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o = st_q.lvl;
endmodule

// File: rtl/ecc_edge_det.sv
module ecc_edge_det
    import ecc_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       lvl_i,
    input  logic [1:0] pol_i,
    output logic       pulse_o,
    output logic       prev_o,
    output logic       err_o
);
    typedef struct packed {
        logic prev;
        logic pulse;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     rise, fall;

    always_comb begin
        st_d      = st_q;
        rise      = lvl_i & ~st_q.prev;
        fall      = ~lvl_i & st_q.prev;
        st_d.prev = lvl_i;
        unique case (pol_e'(pol_i))
            POL_RISE: st_d.pulse = rise;
            POL_FALL: st_d.pulse = fall;
            POL_BOTH: st_d.pulse = rise | fall;
            default:  st_d.pulse = 1'b0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;
    assign prev_o  = st_q.prev;
    assign err_o   = (pol_e'(pol_i) == POL_RSVD);
endmodule

// File: rtl/extclk_edge_cond.sv
module extclk_edge_cond
    import ecc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pin_i,
    input  logic [SEL_W-1:0] flt_sel_i,
    input  logic [1:0]       pol_sel_i,
    output logic             cnt_pulse_o,
    output logic             cfg_err_o
);
    typedef struct packed {
        logic [SEL_W-1:0] flt;
        logic [1:0]       pol;
    } cfg_st_t;

    cfg_st_t cfg_d, cfg_q;
    logic    cfg_chg;
    logic    pin_sync;
    logic    filt_lvl;
    logic    held_lvl;

    always_comb begin
        cfg_d     = cfg_q;
        cfg_d.flt = flt_sel_i;
        cfg_d.pol = pol_sel_i;
        cfg_chg   = (cfg_q.flt != flt_sel_i) || (cfg_q.pol != pol_sel_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    ecc_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(pin_i),
        .sync_o (pin_sync)
    );

    ecc_stab_filter #(.SEL_W(SEL_W)) filt_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .smp_i (pin_sync),
        .sel_i (flt_sel_i),
        .clr_i (cfg_chg),
        .lvl_o (filt_lvl)
    );

    ecc_edge_det edge_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (filt_lvl),
        .pol_i  (pol_sel_i),
        .pulse_o(cnt_pulse_o),
        .prev_o (held_lvl),
        .err_o  (cfg_err_o)
    );
endmodule

// File: rtl/extclk_edge_cond_chk.sv
module extclk_edge_cond_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [1:0] flt_sel_i,
    input logic [1:0] pol_sel_i,
    input logic       cnt_pulse_o,
    input logic       cfg_err_o,
    input logic       pin_sync,
    input logic       filt_lvl,
    input logic       held_lvl
);
    // R1
    no_filter_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flt_sel_i == 2'd0 && $stable(flt_sel_i) && $stable(pol_sel_i) && pin_sync != filt_lvl)
        |=> (filt_lvl == $past(pin_sync)));

    // R6
    both_edges_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (filt_lvl != held_lvl && pol_sel_i == 2'd2) |=> cnt_pulse_o);

    // R7
    rsvd_no_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_err_o |=> !cnt_pulse_o);

    // R8
    single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_pulse_o && pol_sel_i == 2'd0) |=> !cnt_pulse_o);

    // R10
    cfg_change_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(flt_sel_i) |=> $stable(filt_lvl));
endmodule

bind extclk_edge_cond extclk_edge_cond_chk chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flt_sel_i  (flt_sel_i),
    .pol_sel_i  (pol_sel_i),
    .cnt_pulse_o(cnt_pulse_o),
    .cfg_err_o  (cfg_err_o),
    .pin_sync   (pin_sync),
    .filt_lvl   (filt_lvl),
    .held_lvl   (held_lvl)
);

// File: tb/extclk_edge_cond_tb_top.sv
`timescale 1ns/1ps
module extclk_edge_cond_tb_top;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       pin_i = 1'b0;
    logic [1:0] flt_sel_i = 2'd0;
    logic [1:0] pol_sel_i = 2'd0;
    logic       cnt_pulse_o;
    logic       cfg_err_o;

    int checks = 0;
    int fails  = 0;
    int seen_pulses = 0;

    // reference model state
    logic       m_s1 = 0, m_s2 = 0, m_filt = 0, m_prev = 0, m_pulse = 0;
    int         m_run = 0;
    logic [1:0] m_fq = 0, m_pq = 0;

    always #10 clk_i = ~clk_i;

    extclk_edge_cond dut_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pin_i      (pin_i),
        .flt_sel_i  (flt_sel_i),
        .pol_sel_i  (pol_sel_i),
        .cnt_pulse_o(cnt_pulse_o),
        .cfg_err_o  (cfg_err_o)
    );

    function automatic int need_of(input logic [1:0] f);
        return 1 << f;
    endfunction

    function automatic logic exp_pulse(input logic lvl, input logic prv, input logic [1:0] p);
        case (p)
            2'd0: return lvl & ~prv;
            2'd1: return ~lvl & prv;
            2'd2: return lvl ^ prv;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // advance the model by one rising edge using the inputs now applied
    task automatic model_edge();
        logic chg, nxt_pulse;
        chg = (flt_sel_i != m_fq) || (pol_sel_i != m_pq);
        nxt_pulse = exp_pulse(m_filt, m_prev, pol_sel_i);
        m_prev  = m_filt;
        m_pulse = nxt_pulse;
        if (chg || m_s2 == m_filt) m_run = 0;
        else if (m_run + 1 >= need_of(flt_sel_i)) begin m_filt = m_s2; m_run = 0; end
        else m_run = m_run + 1;
        m_s2 = m_s1;
        m_s1 = pin_i;
        m_fq = flt_sel_i;
        m_pq = pol_sel_i;
    endtask

    function automatic string tag_of(input logic [1:0] p, input logic e);
        if (p == 2'd3) return "R7";
        if (!e) return "R3";
        case (p)
            2'd0: return "R4";
            2'd1: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic step(input logic pin, input logic [1:0] f, input logic [1:0] p);
        @(negedge clk_i);
        chk(tag_of(pol_sel_i, m_pulse), cnt_pulse_o, m_pulse);
        chk("R7", cfg_err_o, pol_sel_i == 2'd3);
        if (cnt_pulse_o) seen_pulses++;
        pin_i = pin; flt_sel_i = f; pol_sel_i = p;
        model_edge();
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk_i);
        // R9: reset state
        chk("R9", cnt_pulse_o, 1'b0);
        rst_ni = 1'b1;
        // R9: pin low from reset gives nothing
        seen_pulses = 0;
        for (int i = 0; i < 20; i++) step(1'b0, 2'd0, 2'd2);
        chk("R9", seen_pulses != 0, 1'b0);

        // R11 + R2: latency with count 4, rising edge
        for (int i = 0; i < 12; i++) step(1'b0, 2'd2, 2'd0);
        begin
            int lat = -1;
            step(1'b1, 2'd2, 2'd0);
            for (int i = 1; i <= 12; i++) begin
                @(negedge clk_i);
                if (cnt_pulse_o && lat < 0) lat = i;
                @(posedge clk_i);
            end
            checks++;
            if (lat != 7) begin
                fails++;
                $display("FAIL R11: actual latency %0d expected 7", lat);
            end
        end
        // resync the model with the held-high pin
        m_s1 = 1; m_s2 = 1; m_filt = 1; m_prev = 1; m_pulse = 0; m_run = 0;

        // R3: 7-cycle low pulse against count 8, falling edges
        for (int i = 0; i < 4; i++) step(1'b1, 2'd3, 2'd1);
        seen_pulses = 0;
        for (int i = 0; i < 7; i++) step(1'b0, 2'd3, 2'd1);
        for (int i = 0; i < 14; i++) step(1'b1, 2'd3, 2'd1);
        chk("R3", seen_pulses != 0, 1'b0);

        // R10: field change mid-run delays acceptance
        seen_pulses = 0;
        for (int i = 0; i < 5; i++) step(1'b0, 2'd3, 2'd1);
        for (int i = 0; i < 3; i++) step(1'b0, 2'd1, 2'd1);
        for (int i = 0; i < 8; i++) step(1'b0, 2'd1, 2'd1);
        chk("R10", seen_pulses == 1, 1'b1);

        // R7: reserved code blocks pulses while pin toggles
        seen_pulses = 0;
        for (int i = 0; i < 20; i++) step(i[0], 2'd0, 2'd3);
        step(1'b0, 2'd0, 2'd3);
        chk("R7", seen_pulses != 0, 1'b0);

        // R1/R6/R8: unfiltered toggling at quarter rate, both edges
        seen_pulses = 0;
        for (int i = 0; i < 32; i++) step(i[2], 2'd0, 2'd2);
        chk("R6", seen_pulses >= 6, 1'b1);

        // random phase: runs of random length, occasional field change
        for (int r = 0; r < 600; r++) begin
            logic       lv;
            logic [1:0] f, p;
            int         len;
            lv  = 1'($urandom);
            f   = ($urandom % 8 == 0) ? 2'($urandom) : flt_sel_i;
            p   = ($urandom % 8 == 0) ? 2'($urandom % 3) : pol_sel_i;
            if ($urandom % 40 == 0) p = 2'd3;
            if (pol_sel_i == 2'd3 && p == 2'd3) p = 2'd0;
            len = 1 + ($urandom % 12);
            for (int k = 0; k < len; k++) step(lv, f, p);
        end
        for (int i = 0; i < 16; i++) step(pin_i, flt_sel_i, pol_sel_i);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule